// File: doc/BRIEF.md
# Bit-Serial Key-Schedule Mixing Stage

This block performs one mixing step of a 32-bit add-rotate key schedule, one bit per clock. Four serial streams arrive least significant bit first: the running mix words A and B, a table word S and a key word L. The stage produces two new words. The new A is (S + A + B) rotated left by a fixed amount. The new B is (L + newA + B) rotated left by the low bits of (newA + B). Both leave on serial outputs.

Each addition is a single-bit adder with a registered carry. Each rotation is a two-word shift register read at one of two taps, so there is no barrel shifter and no carry-lookahead logic. A word occupies a frame of W clocks, marked by a start strobe on its bit 0. While one key's word sits in a rotation buffer, the next frame, normally the other interleaved key, moves through the same adders. The stage therefore accepts and delivers one word pair every W clocks. A one-bit slot tag travels with each word, so the consumer can confirm that the two interleaved keys never trade places.

Top module: `keymix_bitser`

## Requirements
- R1: While reset is asserted, and after reset until an input word has had time to emerge, out_start, out_a and out_b are 0.
- R2: For each input word, out_a carries rotl(S + A + B, ROT_S) mod 2^W, with ROT_S = 3 by default.
- R3: For each input word, out_b carries rotl(L + A' + B, (A' + B) mod W), where A' is that word's out_a value.
- R4: All serial words are W bits long and are sent least significant bit first. The start strobe is high on bit 0 only, on both input and output.
- R5: out_tag, sampled while out_start is high, equals the in_tag value that was presented with in_start for that word.
- R6: out_start rises exactly 2W+1 clocks after the in_start of the same word. Back-to-back input frames with alternating tags come out back to back, in the same order.
- R7: The adder carries are cleared at bit 0 of every frame, so an overflowing word adds no carry to the word after it.
- R8: Rotation amounts 0 and W-1 on the B path give the unrotated sum and the sum rotated left by W-1.
- R9: A frame without in_start produces no output frame. Frames after an idle gap are processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_start | input | 1 | High on bit 0 of an input word |
| in_tag | input | 1 | Key-slot tag, sampled with in_start |
| in_a | input | 1 | Serial A bit, LSB first |
| in_b | input | 1 | Serial B bit, LSB first |
| in_s | input | 1 | Serial S bit, LSB first |
| in_l | input | 1 | Serial L bit, LSB first |
| out_start | output | 1 | High on bit 0 of an output word |
| out_tag | output | 1 | Slot tag of the output word |
| out_a | output | 1 | Serial new A bit, LSB first |
| out_b | output | 1 | Serial new B bit, LSB first |

## Verification
The bench builds the stage with its defaults, W = 32 and ROT_S = 3. With these values the data-dependent rotation can take any of 32 amounts, and the bench picks operands that force amounts 0, 1, 16 and 31, so both shift-register taps and the switch between them inside a frame are exercised. The fixed rotation of 3 makes the S path use its upper tap for the first three bits of every frame. A 32-bit word lets the all-ones case carry out of bit 31, which is where a carry leaking between frames would show.

// File: rtl/keymix_pkg.sv
package keymix_pkg;

   // per-frame bookkeeping that travels alongside the serial data
   typedef struct packed {
      logic vld;
      logic tag;
   } slot_t;

   localparam slot_t SLOT_EMPTY = '{vld: 1'b0, tag: 1'b0};

endpackage

// File: rtl/mix_sadd.sv
// Serial adder of NOPS one-bit operands with a registered multi-bit carry.
module mix_sadd #(
   parameter int NOPS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [NOPS-1:0] ops,
   output logic            sum
);
   localparam int CW = $clog2(NOPS);
   localparam int TW = CW + 1;

   generate
      if (NOPS < 2) begin : g_bad_nops
         $error("mix_sadd: NOPS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] carry_q;
   logic [CW-1:0] carry_d;
   logic [TW-1:0] total;

   always_comb begin
      total = clr ? '0 : {1'b0, carry_q};
      for (int i = 0; i < NOPS; i++) begin
         total = total + TW'(ops[i]);
      end
      sum     = total[0];
      carry_d = total[TW-1:1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carry_q <= '0;
      else        carry_q <= carry_d;
   end
endmodule

// File: rtl/mix_dly.sv
// One-frame delay line: bit t of the previous frame appears during bit t.
module mix_dly #(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {din, sr[W-1:1]};
   end

   assign dout = sr[0];
endmodule

// File: rtl/mix_rotbuf.sv
// Two-word shift register that replays the previous frame rotated left.
// During bit t of the replay frame, bit j of the stored word sits at W+j-t,
// so bit (t-r) mod W is at tap W-r when t >= r and at 2W-r otherwise.
module mix_rotbuf #(
   parameter int W       = 32,
   parameter int FIXED_R = -1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 din,
   input  logic [$clog2(W)-1:0] idx,
   input  logic [$clog2(W)-1:0] rot,
   output logic                 dout
);
   localparam int LOG = $clog2(W);
   localparam int AW  = LOG + 1;

   logic [2*W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {din, sr[2*W-1:1]};
   end

   generate
      if (FIXED_R >= 0) begin : g_fixed
         localparam int RF  = FIXED_R % W;
         localparam int TLO = W - RF;
         localparam int THI = (2*W - RF) % (2*W);
         logic unused_rot;
         assign unused_rot = ^rot;
         assign dout = (idx >= LOG'(RF)) ? sr[TLO] : sr[THI];
      end else begin : g_var
         logic [AW-1:0] tap_lo;
         logic [AW-1:0] tap_hi;
         assign tap_lo = AW'(W) - AW'(rot);
         assign tap_hi = AW'(0) - AW'(rot);
         assign dout   = (idx >= rot) ? sr[tap_lo] : sr[tap_hi];
      end
   endgenerate
endmodule

// File: rtl/keymix_bitser.sv
module keymix_bitser #(
   parameter int W     = 32,
   parameter int ROT_S = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_start,
   input  logic in_tag,
   input  logic in_a,
   input  logic in_b,
   input  logic in_s,
   input  logic in_l,
   output logic out_start,
   output logic out_tag,
   output logic out_a,
   output logic out_b
);
   import keymix_pkg::*;

   localparam int LOG = $clog2(W);

   generate
      if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_w
         $error("keymix_bitser: W must be a power of two, at least 8");
      end
      if (ROT_S < 0 || ROT_S >= W) begin : g_bad_rot
         $error("keymix_bitser: ROT_S must lie in 0..W-1");
      end
   endgenerate

   // bit position inside the current frame
   logic [LOG-1:0] idx_q, idx;
   logic           bit0, last;
   assign idx  = in_start ? '0 : idx_q;
   assign bit0 = (idx == '0);
   assign last = (idx == LOG'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx + 1'b1;
   end

   // frame 1: S + A + B, captured for the fixed rotation
   logic sum_sab;
   mix_sadd #(.NOPS(3)) u_add_sab (
      .clk(clk), .rst_n(rst_n), .clr(bit0),
      .ops({in_s, in_a, in_b}), .sum(sum_sab)
   );

   logic new_a;
   mix_rotbuf #(.W(W), .FIXED_R(ROT_S)) u_rot_a (
      .clk(clk), .rst_n(rst_n), .din(sum_sab),
      .idx(idx), .rot('0), .dout(new_a)
   );

   logic b_d, l_d;
   mix_dly #(.W(W)) u_dly_b (.clk(clk), .rst_n(rst_n), .din(in_b), .dout(b_d));
   mix_dly #(.W(W)) u_dly_l (.clk(clk), .rst_n(rst_n), .din(in_l), .dout(l_d));

   // frame 2: L + A' + B and the rotation amount A' + B
   logic sum_lab, sum_ab;
   mix_sadd #(.NOPS(3)) u_add_lab (
      .clk(clk), .rst_n(rst_n), .clr(bit0),
      .ops({l_d, new_a, b_d}), .sum(sum_lab)
   );
   mix_sadd #(.NOPS(2)) u_add_ab (
      .clk(clk), .rst_n(rst_n), .clr(bit0),
      .ops({new_a, b_d}), .sum(sum_ab)
   );

   logic [LOG-1:0] rot_acc, rot_hold;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_acc  <= '0;
         rot_hold <= '0;
      end else begin
         for (int i = 0; i < LOG; i++) begin
            if (idx == LOG'(i)) rot_acc[i] <= sum_ab;
         end
         if (last) rot_hold <= rot_acc;
      end
   end

   // frame 3: replay both results
   logic new_b, a_d;
   mix_rotbuf #(.W(W), .FIXED_R(-1)) u_rot_b (
      .clk(clk), .rst_n(rst_n), .din(sum_lab),
      .idx(idx), .rot(rot_hold), .dout(new_b)
   );
   mix_dly #(.W(W)) u_dly_a (.clk(clk), .rst_n(rst_n), .din(new_a), .dout(a_d));

   // slot tags move one stage per frame boundary
   slot_t slot_in, slot_mid, slot_out;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_in  <= SLOT_EMPTY;
         slot_mid <= SLOT_EMPTY;
         slot_out <= SLOT_EMPTY;
      end else if (last) begin
         slot_in  <= SLOT_EMPTY;
         slot_mid <= slot_in;
         slot_out <= slot_mid;
      end else if (in_start) begin
         slot_in  <= '{vld: 1'b1, tag: in_tag};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_start <= 1'b0;
         out_tag   <= 1'b0;
         out_a     <= 1'b0;
         out_b     <= 1'b0;
      end else begin
         out_start <= bit0 & slot_out.vld;
         out_tag   <= bit0 ? slot_out.tag : out_tag;
         out_a     <= a_d & slot_out.vld;
         out_b     <= new_b & slot_out.vld;
      end
   end
endmodule

// File: rtl/keymix_bitser_chk.sv
module keymix_bitser_chk #(
   parameter int W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic in_start,
   input logic in_tag,
   input logic out_start,
   input logic out_tag
);
   localparam int LAT = 2*W + 1;

   logic [31:0] cyc;
   logic [31:0] q_stamp [4];
   logic        q_tag   [4];
   logic [1:0]  wp, rp;
   logic [31:0] since_out, since_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc       <= '0;
         wp        <= '0;
         rp        <= '0;
         since_out <= 32'(W);
         since_in  <= 32'(LAT + 1);
         for (int i = 0; i < 4; i++) begin
            q_stamp[i] <= '0;
            q_tag[i]   <= 1'b0;
         end
      end else begin
         cyc <= cyc + 1;
         if (in_start) begin
            q_stamp[wp] <= cyc;
            q_tag[wp]   <= in_tag;
            wp          <= wp + 1'b1;
         end
         if (out_start) rp <= rp + 1'b1;
         since_out <= out_start ? 32'd1 : (since_out < 32'(W) ? since_out + 1 : since_out);
         since_in  <= in_start ? 32'd1 : (since_in <= 32'(LAT) ? since_in + 1 : since_in);
      end
   end

   a_r5_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> (wp != rp) && (q_tag[rp] == out_tag));

   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> (cyc - q_stamp[rp]) == 32'(LAT));

   a_r4_frame_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> since_out >= 32'(W));

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> since_in <= 32'(LAT));
endmodule

bind keymix_bitser keymix_bitser_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_tag(in_tag),
   .out_start(out_start), .out_tag(out_tag)
);

// File: tb/keymix_bitser_tb.sv
module keymix_bitser_tb;
   localparam int W      = 32;
   localparam int PERIOD = 10;
   localparam int NQ     = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_start = 1'b0, in_tag = 1'b0;
   logic in_a = 1'b0, in_b = 1'b0, in_s = 1'b0, in_l = 1'b0;
   logic out_start, out_tag, out_a, out_b;

   always #(PERIOD/2) clk = ~clk;

   keymix_bitser #(.W(W), .ROT_S(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_tag(in_tag),
      .in_a(in_a), .in_b(in_b), .in_s(in_s), .in_l(in_l),
      .out_start(out_start), .out_tag(out_tag), .out_a(out_a), .out_b(out_b)
   );

   int tests = 0, fails = 0;
   int pcyc = 0;
   always @(posedge clk) pcyc <= pcyc + 1;

   logic [31:0] exp_a [NQ];
   logic [31:0] exp_b [NQ];
   logic        exp_t [NQ];
   int          exp_c [NQ];
   string       exp_l [NQ];
   int wr = 0, rd = 0;
   bit done = 0;

   function automatic logic [31:0] rotl(input logic [31:0] x, input int r);
      int rr = r % 32;
      return (rr == 0) ? x : ((x << rr) | (x >> (32 - rr)));
   endfunction

   function automatic logic [31:0] ref_a(input logic [31:0] a, b, s);
      return rotl(s + a + b, 3);
   endfunction

   function automatic logic [31:0] ref_b(input logic [31:0] a, b, s, l);
      logic [31:0] na = ref_a(a, b, s);
      logic [31:0] t  = na + b;
      return rotl(l + na + b, int'(t[4:0]));
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // drive one W-bit frame, LSB first, start on bit 0
   task automatic send(input logic [31:0] a, b, s, l, input logic tag, input string lbl);
      exp_a[wr] = ref_a(a, b, s);
      exp_b[wr] = ref_b(a, b, s, l);
      exp_t[wr] = tag;
      exp_l[wr] = lbl;
      for (int k = 0; k < W; k++) begin
         @(negedge clk);
         if (k == 0) exp_c[wr] = pcyc;
         in_start = (k == 0);
         in_tag   = tag;
         in_a = a[k]; in_b = b[k]; in_s = s[k]; in_l = l[k];
      end
      wr++;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_start = 1'b0;
         in_a = 1'b0; in_b = 1'b0; in_s = 1'b0; in_l = 1'b0;
      end
   endtask

   // search random operands whose B-path rotation equals target
   task automatic send_rot(input int target, input logic tag, input string lbl);
      logic [31:0] a, b, s, l, t;
      for (int n = 0; n < 4000; n++) begin
         a = $urandom; b = $urandom; s = $urandom; l = $urandom;
         t = ref_a(a, b, s) + b;
         if (int'(t[4:0]) == target) break;
      end
      send(a, b, s, l, tag, lbl);
   endtask

   // output monitor: deserialize and compare
   logic [31:0] got_a, got_b;
   logic        got_t;
   int          got_c;
   int          kcol = -1;
   int          words = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_start) begin
            kcol  = 0;
            got_t = out_tag;
            got_c = pcyc;
         end
         if (kcol >= 0) begin
            got_a[kcol] = out_a;
            got_b[kcol] = out_b;
            kcol++;
            if (kcol == W) begin
               kcol = -1;
               if (rd >= wr) begin
                  check(1'b0, "R9", "output word with no input", got_a, 32'h0);
               end else begin
                  check(got_a == exp_a[rd], exp_l[rd] == "" ? "R2" : exp_l[rd], "out_a", got_a, exp_a[rd]);
                  check(got_b == exp_b[rd], exp_l[rd] == "" ? "R3" : exp_l[rd], "out_b", got_b, exp_b[rd]);
                  check(got_t == exp_t[rd], "R5", "out_tag", 32'(got_t), 32'(exp_t[rd]));
                  check(got_c - exp_c[rd] == 2*W + 1, "R6", "latency", 32'(got_c - exp_c[rd]), 32'(2*W + 1));
                  rd++;
               end
               words++;
            end
         end
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20040807));
      // R1: reset state
      repeat (4) @(negedge clk);
      check(out_start == 0 && out_a == 0 && out_b == 0, "R1", "outputs in reset",
            {29'd0, out_start, out_a, out_b}, 32'h0);
      rst_n = 1'b1;
      idle(80);
      check(words == 0 && out_start == 0 && out_a == 0 && out_b == 0, "R1", "outputs after reset",
            32'(words), 32'h0);

      // R4: a single one at bit 0 of A lands at bit 3 of the new A
      send(32'h1, 32'h0, 32'h0, 32'h0, 1'b0, "R4");
      // R7: overflowing word followed by all-zero word
      send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7");
      send(32'h0, 32'h0, 32'h0, 32'h0, 1'b0, "R7");
      // R8: rotation amount corner cases on the B path
      send_rot(0,  1'b1, "R8");
      send_rot(31, 1'b0, "R8");
      send_rot(1,  1'b1, "R8");
      send_rot(16, 1'b0, "R8");

      // R2 R3 R5 R6: two interleaved keys, random words back to back
      for (int f = 0; f < 40; f++) begin
         send($urandom, $urandom, $urandom, $urandom, f[0], "");
      end
      // R9: idle gap of three frames, then resume
      idle(3 * W);
      for (int f = 0; f < 6; f++) begin
         send($urandom, $urandom, $urandom, $urandom, ~f[0], "");
      end
      idle(3 * W + 8);

      check(words == wr, "R9", "word count", 32'(words), 32'(wr));
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule